// File: doc/BRIEF.md
# Direct-Mapped Write-Through Cache with Critical-Word-First Refill

This block is a direct-mapped cache for 32-bit byte addresses. Each line holds four 32-bit words under a single valid bit and a single tag. The processor sees a simple request interface: it raises a request and holds the address, write flag and write data until the cache answers with a ready pulse. A hit completes in the same cycle. A miss starts a refill, one word at a time, from main memory.

The refill fetches the requested word first and then the remaining words in ascending order, wrapping around within the line. The processor is released in the cycle the word it asked for arrives, while the rest of the line keeps filling. Writes are write-through with allocate on a miss. A write that misses fetches the line, merges the new word as it arrives, and sends the word to memory. A write that hits updates the line and sends the word to memory in the same cycle.

While a refill is in progress, other accesses are still served where possible. A word of the filling line that has already arrived is served at once, and so is a hit to any other line. An access to a word that has not yet arrived waits for that word. A miss to another line waits until the refill ends.

Top module: `wtCache`

## Requirements
- R1: Address bits [3:2] select the word within a line, the next IDX_BITS bits select the line (block address modulo the line count), the remaining upper bits form the tag, and bits [1:0] do not affect which word is read.
- R2: After reset every line is invalid: the first access to any address is a miss, and with no request, cpuReady, memRdReq and memWrEn are all 0.
- R3: A read whose line is valid with a matching tag completes in the same cycle (cpuReady=1), returns the stored word on cpuRdata, and issues no memory read.
- R4: A miss fetches exactly four words, one request at a time. The first request is the requested word, and each later one is the previous word offset plus 1 modulo 4 in the same line. memRdReq stays high with a stable memRdAddr until memRdValid accepts the word.
- R5: A missing access completes in the cycle its own word arrives (memRdValid=1 with memRdAddr equal to the word-aligned request), and the refill continues afterwards with memRdReq still high.
- R6: The line becomes valid with its new tag only once all four words are in. memRdReq drops in the cycle after the fourth word, and every word of the line then hits.
- R7: A write hit updates the word, completes in the same cycle, and pulses memWrEn for that cycle with memWrAddr equal to the word-aligned address and memWrData equal to the write data.
- R8: A write miss first fetches the line. It completes in the cycle the addressed word arrives, storing the write data in place of the fetched word and pulsing memWrEn. Later reads return the written word and the fetched neighbours.
- R9: During a refill, an access to a word of the filling line that has already arrived completes immediately. An access to a word not yet arrived completes exactly in the cycle that word arrives. A write to an arrived word that coincides with the arrival of another word waits one cycle.
- R10: During a refill, a hit to a different line completes immediately. A miss to any other line, including the same index with a different tag, waits until the refill ends and then starts its own refill.
- R11: cpuReady is asserted only while cpuReq is high, and memWrEn is asserted only in the cycle a write completes.
- R12: Two addresses with the same index and different tags evict each other. After the second one is filled, the first one misses again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpuReq | input | 1 | Processor access request, held until cpuReady |
| cpuWe | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | 32 | Byte address of the access |
| cpuWdata | input | 32 | Write data |
| cpuRdata | output | 32 | Read data, valid when cpuReady is high on a read |
| cpuReady | output | 1 | Access completes this cycle |
| memRdReq | output | 1 | Word read request to memory, held during a refill |
| memRdAddr | output | 32 | Word-aligned address of the requested word |
| memRdValid | input | 1 | Memory returns the requested word this cycle |
| memRdData | input | 32 | Word returned by memory |
| memWrEn | output | 1 | Write-through strobe, one cycle per write |
| memWrAddr | output | 32 | Word-aligned write-through address |
| memWrData | output | 32 | Write-through data |

## Verification
The bench builds the cache with IDX_BITS=4: 16 lines and a 24-bit tag. With this setting, addresses 256 bytes apart collide on one line, which makes eviction between same-index addresses easy to reach. The example byte address 131408 lands on line 5. The bench memory answers each word two cycles after the request. This leaves a wide window inside each refill, so that accesses to arrived words, not-yet-arrived words, other-line hits and other-line misses can each be placed while a refill is in progress.

// File: rtl/wtc_pkg.sv
`timescale 1ns/1ps
package wtc_pkg;
  localparam int ADDR_W = 32;
  localparam int WORD_W = 32;
  localparam int OFF_W  = 2;
  localparam int WORDS  = 1 << OFF_W;

  // strobes from control to datapath
  typedef struct packed {
    logic wordWe;    // write one data word this cycle
    logic srcCpu;    // word comes from the processor, else from memory
    logic useFill;   // address the line and word of the refill
    logic lineInval; // clear valid of the requested line
    logic lineSet;   // write tag and set valid of the refill line
    logic rdBypass;  // return memory data straight to the processor
  } ctrlStrobes_t;
endpackage

// File: rtl/wtcDatapath.sv
`timescale 1ns/1ps
module wtcDatapath #(
  parameter int IDX_BITS = 6
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [29:0]               wordAddr,
  input  logic [31:0]               cpuWdata,
  input  logic [31:0]               memRdData,
  input  wtc_pkg::ctrlStrobes_t     strb,
  input  logic [IDX_BITS-1:0]       fillIdx,
  input  logic [1:0]                fillOff,
  input  logic [29-IDX_BITS-2+1:0]  fillTag,
  output logic [29-IDX_BITS-2+1:0]  reqTag,
  output logic [IDX_BITS-1:0]       reqIdx,
  output logic [1:0]                reqOff,
  output logic                      hit,
  output logic [31:0]               rdData
);
  import wtc_pkg::*;
  localparam int LINES = 1 << IDX_BITS;
  localparam int TAG_W = ADDR_W - IDX_BITS - OFF_W - 2;

  logic [LINES-1:0]  validQ;
  logic [TAG_W-1:0]  tagQ  [LINES];
  logic [WORD_W-1:0] dataQ [LINES][WORDS];

  logic [IDX_BITS-1:0] wrIdx;
  logic [OFF_W-1:0]    wrOff;
  logic [WORD_W-1:0]   wrVal;

  assign reqOff = wordAddr[OFF_W-1:0];
  assign reqIdx = wordAddr[IDX_BITS+OFF_W-1:OFF_W];
  assign reqTag = wordAddr[29:IDX_BITS+OFF_W];

  assign hit    = validQ[reqIdx] && (tagQ[reqIdx] == reqTag);
  assign rdData = strb.rdBypass ? memRdData : dataQ[reqIdx][reqOff];

  assign wrIdx = strb.useFill ? fillIdx : reqIdx;
  assign wrOff = strb.useFill ? fillOff : reqOff;
  assign wrVal = strb.srcCpu  ? cpuWdata : memRdData;

  always_ff @(posedge clk) begin
    if (rst) begin
      validQ <= '0;
    end else begin
      if (strb.lineInval) validQ[reqIdx] <= 1'b0;
      if (strb.lineSet) begin
        validQ[fillIdx] <= 1'b1;
        tagQ[fillIdx]   <= fillTag;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strb.wordWe) dataQ[wrIdx][wrOff] <= wrVal;
  end
endmodule

// File: rtl/wtcControl.sv
`timescale 1ns/1ps
module wtcControl #(
  parameter int IDX_BITS = 6
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cpuReq,
  input  logic                      cpuWe,
  input  logic [29-IDX_BITS-2+1:0]  reqTag,
  input  logic [IDX_BITS-1:0]       reqIdx,
  input  logic [1:0]                reqOff,
  input  logic                      hit,
  input  logic                      memRdValid,
  output wtc_pkg::ctrlStrobes_t     strb,
  output logic [IDX_BITS-1:0]       fillIdx,
  output logic [1:0]                fillOff,
  output logic [29-IDX_BITS-2+1:0]  fillTag,
  output logic                      cpuReady,
  output logic                      memWrEn,
  output logic                      memRdReq,
  output logic [31:0]               memRdAddr
);
  import wtc_pkg::*;
  localparam int TAG_W = ADDR_W - IDX_BITS - OFF_W - 2;

  typedef enum logic {S_IDLE, S_FILL} state_t;

  state_t              stateQ;
  logic [TAG_W-1:0]    fillTagQ;
  logic [IDX_BITS-1:0] fillIdxQ;
  logic [1:0]          critQ;
  logic [1:0]          cntQ;
  logic [WORDS-1:0]    presentQ;

  logic inFill, arrive, sameLine;

  assign inFill   = (stateQ == S_FILL);
  assign arrive   = inFill && memRdValid;
  assign sameLine = inFill && (reqTag == fillTagQ) && (reqIdx == fillIdxQ);
  assign fillOff  = critQ + cntQ;
  assign fillIdx  = fillIdxQ;
  assign fillTag  = fillTagQ;
  assign memRdReq = inFill;
  assign memRdAddr = {fillTagQ, fillIdxQ, fillOff, 2'b00};

  always_comb begin
    strb     = '0;
    cpuReady = 1'b0;
    memWrEn  = 1'b0;
    if (arrive) begin
      strb.wordWe  = 1'b1;
      strb.useFill = 1'b1;
      strb.lineSet = (cntQ == 2'd3);
    end
    if (cpuReq) begin
      if (!inFill) begin
        if (hit) begin
          cpuReady = 1'b1;
          if (cpuWe) begin
            strb.wordWe = 1'b1;
            strb.srcCpu = 1'b1;
            memWrEn     = 1'b1;
          end
        end else begin
          strb.lineInval = 1'b1;
        end
      end else if (sameLine) begin
        if (arrive && reqOff == fillOff) begin
          // early restart: the word being delivered is the one asked for
          cpuReady = 1'b1;
          if (cpuWe) begin
            strb.srcCpu = 1'b1;
            memWrEn     = 1'b1;
          end else begin
            strb.rdBypass = 1'b1;
          end
        end else if (presentQ[reqOff] && !(cpuWe && arrive)) begin
          cpuReady = 1'b1;
          if (cpuWe) begin
            strb.wordWe = 1'b1;
            strb.srcCpu = 1'b1;
            memWrEn     = 1'b1;
          end
        end
      end else if (hit && !(cpuWe && arrive)) begin
        cpuReady = 1'b1;
        if (cpuWe) begin
          strb.wordWe = 1'b1;
          strb.srcCpu = 1'b1;
          memWrEn     = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ   <= S_IDLE;
      fillTagQ <= '0;
      fillIdxQ <= '0;
      critQ    <= '0;
      cntQ     <= '0;
      presentQ <= '0;
    end else if (!inFill) begin
      if (cpuReq && !hit) begin
        stateQ   <= S_FILL;
        fillTagQ <= reqTag;
        fillIdxQ <= reqIdx;
        critQ    <= reqOff;
        cntQ     <= '0;
        presentQ <= '0;
      end
    end else if (memRdValid) begin
      presentQ[fillOff] <= 1'b1;
      cntQ              <= cntQ + 2'd1;
      if (cntQ == 2'd3) stateQ <= S_IDLE;
    end
  end
endmodule

// File: rtl/wtCache.sv
`timescale 1ns/1ps
module wtCache #(
  parameter int IDX_BITS = 6
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cpuReq,
  input  logic        cpuWe,
  input  logic [31:0] cpuAddr,
  input  logic [31:0] cpuWdata,
  output logic [31:0] cpuRdata,
  output logic        cpuReady,
  output logic        memRdReq,
  output logic [31:0] memRdAddr,
  input  logic        memRdValid,
  input  logic [31:0] memRdData,
  output logic        memWrEn,
  output logic [31:0] memWrAddr,
  output logic [31:0] memWrData
);
  localparam int TAG_W = 32 - IDX_BITS - 4;

  wtc_pkg::ctrlStrobes_t strb;
  logic [TAG_W-1:0]    reqTag, fillTag;
  logic [IDX_BITS-1:0] reqIdx, fillIdx;
  logic [1:0]          reqOff, fillOff;
  logic                hit;

  assign memWrAddr = cpuAddr & ~32'd3;
  assign memWrData = cpuWdata;

  wtcDatapath #(.IDX_BITS(IDX_BITS)) dp (
    .clk(clk), .rst(rst), .wordAddr(cpuAddr[31:2]), .cpuWdata(cpuWdata),
    .memRdData(memRdData), .strb(strb), .fillIdx(fillIdx), .fillOff(fillOff),
    .fillTag(fillTag), .reqTag(reqTag), .reqIdx(reqIdx), .reqOff(reqOff),
    .hit(hit), .rdData(cpuRdata)
  );

  wtcControl #(.IDX_BITS(IDX_BITS)) ctl (
    .clk(clk), .rst(rst), .cpuReq(cpuReq), .cpuWe(cpuWe), .reqTag(reqTag),
    .reqIdx(reqIdx), .reqOff(reqOff), .hit(hit), .memRdValid(memRdValid),
    .strb(strb), .fillIdx(fillIdx), .fillOff(fillOff), .fillTag(fillTag),
    .cpuReady(cpuReady), .memWrEn(memWrEn), .memRdReq(memRdReq),
    .memRdAddr(memRdAddr)
  );
endmodule

// File: rtl/wtcChecker.sv
`timescale 1ns/1ps
module wtcChecker (
  input logic        clk,
  input logic        rst,
  input logic        cpuReq,
  input logic        cpuWe,
  input logic        cpuReady,
  input logic        memRdReq,
  input logic [31:0] memRdAddr,
  input logic        memRdValid,
  input logic        memWrEn
);
  logic [2:0] wordCnt;

  always_ff @(posedge clk) begin
    if (rst || !memRdReq) wordCnt <= '0;
    else if (memRdValid)  wordCnt <= wordCnt + 3'd1;
  end

  AST_READY_HAS_REQ: assert property (@(posedge clk) disable iff (rst)
    cpuReady |-> cpuReq); // R11
  AST_WRITE_THROUGH: assert property (@(posedge clk) disable iff (rst)
    (cpuReq && cpuWe && cpuReady) |-> memWrEn); // R7
  AST_WR_ONLY_DONE: assert property (@(posedge clk) disable iff (rst)
    memWrEn |-> (cpuReq && cpuWe && cpuReady)); // R11
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (memRdReq && !memRdValid) |=> (memRdReq && $stable(memRdAddr))); // R4
  AST_WRAP_ORDER: assert property (@(posedge clk) disable iff (rst)
    (memRdReq && memRdValid && wordCnt < 3'd3) |=>
      (memRdReq && memRdAddr[31:4] == $past(memRdAddr[31:4]) &&
       memRdAddr[3:2] == $past(memRdAddr[3:2]) + 2'd1)); // R4
  AST_FILL_DONE: assert property (@(posedge clk) disable iff (rst)
    (memRdReq && memRdValid && wordCnt == 3'd3) |=> !memRdReq); // R6
endmodule

bind wtCache wtcChecker chk (
  .clk(clk), .rst(rst), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuReady(cpuReady),
  .memRdReq(memRdReq), .memRdAddr(memRdAddr), .memRdValid(memRdValid),
  .memWrEn(memWrEn)
);

// File: tb/wtCache_test.sv
`timescale 1ns/1ps
module wtCache_test;
  localparam int IDX_BITS = 4;
  localparam int LAT = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic cpuReq = 1'b0, cpuWe = 1'b0;
  logic [31:0] cpuAddr = '0, cpuWdata = '0, cpuRdata;
  logic cpuReady, memRdReq, memRdValid = 1'b0, memWrEn;
  logic [31:0] memRdAddr, memRdData = '0, memWrAddr, memWrData;

  wtCache #(.IDX_BITS(IDX_BITS)) uut (
    .clk(clk), .rst(rst), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuRdata(cpuRdata), .cpuReady(cpuReady),
    .memRdReq(memRdReq), .memRdAddr(memRdAddr), .memRdValid(memRdValid),
    .memRdData(memRdData), .memWrEn(memWrEn), .memWrAddr(memWrAddr),
    .memWrData(memWrData)
  );

  always #2.5 clk = ~clk;

  int nChecks = 0, nFail = 0;
  string curTag = "";
  logic [31:0] refMem [logic [31:0]];
  logic [31:0] memArr [logic [31:0]];
  logic [31:0] expRd[$];
  logic [63:0] expWr[$];
  logic [31:0] rdLog[$];
  int waitCyc;
  logic vAt, qAt;
  logic [31:0] aAt;
  int lat = 0;

  function automatic logic [31:0] initWord(input logic [31:0] a);
    return a * 32'h9E3779B1 + 32'h1234_5678;
  endfunction
  function automatic logic [31:0] refGet(input logic [31:0] a);
    if (refMem.exists(a)) return refMem[a];
    return initWord(a);
  endfunction
  function automatic logic [31:0] memGet(input logic [31:0] a);
    if (memArr.exists(a)) return memArr[a];
    return initWord(a);
  endfunction

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  // memory model: one word per request, LAT idle cycles before each answer
  initial forever begin
    @(negedge clk);
    if (memRdValid) memRdValid = 1'b0;
    else if (memRdReq) begin
      if (lat >= LAT) begin
        memRdValid = 1'b1;
        memRdData  = memGet(memRdAddr);
        rdLog.push_back(memRdAddr);
        lat = 0;
      end else lat++;
    end else lat = 0;
  end

  // monitor: compares completed reads and write-through traffic
  initial forever begin
    @(negedge clk);
    #2;
    if (cpuReq && cpuReady && !cpuWe) begin
      if (expRd.size() == 0) chk(0, {curTag, " unexpected read"}, cpuRdata, 32'h0);
      else begin
        logic [31:0] e;
        e = expRd.pop_front();
        chk(cpuRdata == e, {curTag, " read data"}, cpuRdata, e);
      end
    end
    if (memWrEn) begin
      memArr[memWrAddr] = memWrData;
      if (expWr.size() == 0) chk(0, {curTag, " unexpected write-through"}, memWrAddr, 32'h0);
      else begin
        logic [63:0] e;
        e = expWr.pop_front();
        chk(memWrAddr == e[63:32], {curTag, " write-through addr"}, memWrAddr, e[63:32]);
        chk(memWrData == e[31:0], {curTag, " write-through data"}, memWrData, e[31:0]);
      end
    end
  end

  task automatic access(input bit we, input logic [31:0] addr, input logic [31:0] data);
    logic [31:0] al;
    al = addr & ~32'd3;
    @(negedge clk);
    if (we) begin
      refMem[al] = data;
      expWr.push_back({al, data});
    end else expRd.push_back(refGet(al));
    cpuReq = 1'b1; cpuWe = we; cpuAddr = addr; cpuWdata = data;
    waitCyc = 0;
    forever begin
      #2;
      if (cpuReady) begin
        vAt = memRdValid; aAt = memRdAddr; qAt = memRdReq;
        break;
      end
      waitCyc++;
      if (waitCyc > 500) begin
        chk(0, {curTag, " access never completed"}, addr, addr);
        break;
      end
      @(negedge clk);
    end
    @(posedge clk);
    #1;
    cpuReq = 1'b0; cpuWe = 1'b0;
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (memRdReq) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #2;
    curTag = "R2";
    chk(cpuReady == 1'b0, "R2 reset cpuReady", {31'b0, cpuReady}, 32'h0);
    chk(memRdReq == 1'b0, "R2 reset memRdReq", {31'b0, memRdReq}, 32'h0);
    chk(memWrEn == 1'b0, "R2 reset memWrEn", {31'b0, memWrEn}, 32'h0);

    // cold read miss, word 2 of byte address 131408's line (line 5)
    curTag = "R5";
    rdLog.delete();
    access(0, 32'h0002_0158, 0);
    chk(waitCyc == LAT + 1, "R2 cold access is a miss, wait", waitCyc, LAT + 1);
    chk(vAt && aAt == 32'h0002_0158, "R5 released on arrival of requested word", aAt, 32'h0002_0158);
    chk(qAt == 1'b1, "R5 refill continues after release", {31'b0, qAt}, 32'h1);
    waitIdle();
    curTag = "R4";
    chk(rdLog.size() == 4, "R4 four words fetched", rdLog.size(), 4);
    if (rdLog.size() == 4) begin
      chk(rdLog[0] == 32'h0002_0158, "R4 order word0", rdLog[0], 32'h0002_0158);
      chk(rdLog[1] == 32'h0002_015C, "R4 order word1", rdLog[1], 32'h0002_015C);
      chk(rdLog[2] == 32'h0002_0150, "R4 order word2 wraps", rdLog[2], 32'h0002_0150);
      chk(rdLog[3] == 32'h0002_0154, "R4 order word3", rdLog[3], 32'h0002_0154);
    end

    curTag = "R6";
    access(0, 32'h0002_0150, 0);
    chk(waitCyc == 0, "R6 filled line hits", waitCyc, 0);
    curTag = "R3";
    access(0, 32'h0002_015C, 0);
    chk(waitCyc == 0, "R3 read hit same cycle", waitCyc, 0);
    chk(rdLog.size() == 4, "R3 hit issues no memory read", rdLog.size(), 4);
    curTag = "R1";
    access(0, 32'h0002_0153, 0);
    chk(waitCyc == 0, "R1 byte offset ignored, hit", waitCyc, 0);

    // same line index, different tag: 256 bytes apart with 16 lines
    curTag = "R12";
    access(0, 32'h0002_0254, 0);
    chk(waitCyc == LAT + 1, "R12 conflicting tag misses", waitCyc, LAT + 1);
    waitIdle();
    access(0, 32'h0002_0150, 0);
    chk(waitCyc == LAT + 1, "R12 evicted line misses again", waitCyc, LAT + 1);
    waitIdle();
    curTag = "R1";
    access(0, 32'h0002_0160, 0);
    chk(waitCyc == LAT + 1, "R1 next block maps to another line", waitCyc, LAT + 1);
    waitIdle();

    curTag = "R7";
    rdLog.delete();
    access(1, 32'h0002_0154, 32'hDEAD_0001);
    chk(waitCyc == 0, "R7 write hit same cycle", waitCyc, 0);
    access(0, 32'h0002_0154, 0);
    chk(waitCyc == 0, "R7 written word read back", waitCyc, 0);
    chk(rdLog.size() == 0, "R7 write hit issues no memory read", rdLog.size(), 0);

    curTag = "R8";
    access(1, 32'h0003_0008, 32'hBEEF_0002);
    chk(waitCyc == LAT + 1, "R8 write miss waits for fetch", waitCyc, LAT + 1);
    chk(vAt && aAt == 32'h0003_0008, "R8 merged on arrival", aAt, 32'h0003_0008);
    waitIdle();
    access(0, 32'h0003_0008, 0);
    chk(waitCyc == 0, "R8 merged word hits", waitCyc, 0);
    access(0, 32'h0003_0000, 0);
    chk(waitCyc == 0, "R8 neighbour fetched", waitCyc, 0);

    curTag = "R9";
    access(0, 32'h0004_000C, 0);
    access(0, 32'h0004_0004, 0);
    chk(waitCyc > 0, "R9 not-yet-arrived word stalls", waitCyc, 1);
    chk(vAt && aAt == 32'h0004_0004, "R9 served on its arrival", aAt, 32'h0004_0004);
    access(0, 32'h0004_000C, 0);
    chk(waitCyc == 0 && qAt, "R9 arrived word served during refill", waitCyc, 0);
    waitIdle();

    curTag = "R10";
    rdLog.delete();
    access(0, 32'h0005_0000, 0);
    access(0, 32'h0002_0150, 0);
    chk(waitCyc == 0 && qAt, "R10 other-line hit during refill", waitCyc, 0);
    access(0, 32'h0006_0010, 0);
    chk(vAt && aAt == 32'h0006_0010, "R10 other-line miss starts after refill", aAt, 32'h0006_0010);
    chk(rdLog.size() >= 5 && rdLog[4] == 32'h0006_0010, "R10 prior refill completed first",
        rdLog.size() >= 5 ? rdLog[4] : 32'h0, 32'h0006_0010);
    curTag = "R9";
    access(1, 32'h0006_0010, 32'hCAFE_0003);
    chk(waitCyc == 0, "R9 write to arrived word during refill", waitCyc, 0);
    waitIdle();
    access(0, 32'h0006_0010, 0);
    chk(waitCyc == 0, "R9 written word kept after refill", waitCyc, 0);

    @(negedge clk); #2;
    curTag = "R11";
    chk(cpuReady == 1'b0 && memWrEn == 1'b0, "R11 idle outputs quiet",
        {30'b0, cpuReady, memWrEn}, 32'h0);
    chk(expRd.size() == 0 && expWr.size() == 0, "R11 all expected items seen",
        expRd.size() + expWr.size(), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule